// File: doc/BRIEF.md
# Masked CAN Identifier Acceptance Filter

This block decides whether a received CAN message gets accepted. A 32-bit filter is built from four acceptance-code bytes and four mask bytes. Each received identifier byte is compared bit by bit with its code byte. A mask bit of 1 makes that bit position a don't-care. The message is accepted only when every bit that still matters matches.

The eight filter bytes sit behind a byte-wide register port. They can be changed only while the controller's configuration (soft-reset) mode input is high; a write at any other time is dropped. The block's reset does not touch them, so a filter that software has programmed survives a controller reset. All eight bytes can be read back at any time.

Each comparison is started by a one-cycle strobe that comes with the identifier. The verdict appears on a registered output and stays there until the next strobe.

Top module: `id_accept_filter`

## Requirements
- R1: For a bit whose mask bit is 0, the identifier bit must equal the code bit. With all mask bytes 0x00, only an identifier that is identical to the 32-bit code is accepted.
- R2: For a bit whose mask bit is 1, the identifier bit has no effect on the verdict. With all mask bytes 0xFF, every identifier is accepted.
- R3: The verdict is accept exactly when (identifier XOR code) AND NOT mask is zero over all 32 bits. Identifier byte k sits in `id_bytes[8k+7:8k]` and uses code byte k and mask byte k.
- R4: A register write takes effect only while `cfg_mode` is 1. When `cfg_mode` is 0, a write leaves all eight filter bytes unchanged.
- R5: The filter bytes are not changed by `rst`. Their contents before a reset pulse can be read back unchanged after it.
- R6: Register address map, readable in any mode on `reg_rdata` (combinational from `reg_addr`): addresses 0 to 3 hold code bytes 0 to 3, and addresses 4 to 7 hold mask bytes 0 to 3.
- R7: `accept` is registered. It takes the verdict for the identifier present on the clock edge where `id_valid` is 1, and it holds its value on every edge where `id_valid` is 0.
- R8: While `rst` is high, `accept` is cleared to 0 on each clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears only the verdict register |
| cfg_mode | input | 1 | Configuration (soft-reset) mode; 1 unlocks filter writes |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both writes and reads |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| id_valid | input | 1 | One-cycle strobe: compare `id_bytes` on this edge |
| id_bytes | input | 32 | Received identifier bytes; byte k in bits 8k+7:8k |
| accept | output | 1 | Registered accept verdict |

## Verification
The bench builds the block with its default four-byte filter. This keeps the whole 32-bit filter small enough to sweep every bit position on its own. Each position is flipped against an exact-match filter, once with its mask bit clear and once with it set. Several hundred further vectors use pseudo-random codes, masks and identifiers with a partial agreement pattern, and their expected verdict is computed directly as ((id XOR code) AND NOT mask) == 0. The register map is read back after locked writes and after a reset pulse. The verdict is also checked while it is held between strobes.

// File: rtl/idf_pkg.sv
package idf_pkg;

    // Architectural register width: every filter register is one byte.
    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // The top address bit selects the register bank.
    typedef enum logic {
        BANK_CODE = 1'b0,
        BANK_MASK = 1'b1
    } bank_e;

    // A compare event that travels from the comparator to the verdict register.
    typedef struct packed {
        logic valid;
        logic hit;
    } cmp_res_t;

    // Per-byte masked equality: a set mask bit forgives a mismatch.
    function automatic logic byte_match(input byte_t id_b, input byte_t code_b, input byte_t mask_b);
        return &(~(id_b ^ code_b) | mask_b);
    endfunction

endpackage

// File: rtl/idf_regbank.sv
module idf_regbank
    import idf_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned IDX_W  = $clog2(NUM_BYTES),
    localparam int unsigned ADDR_W = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_mode,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  byte_t                         wr_data,
    output byte_t                         rd_data,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0] code_q,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0] mask_q
);

    bank_e            bank;
    logic [IDX_W-1:0] idx;
    logic             wr_ok;

    assign bank  = bank_e'(addr[ADDR_W-1]);
    assign idx   = addr[IDX_W-1:0];
    assign wr_ok = wr_en && cfg_mode;

    // Filter storage has no reset: contents persist until rewritten.
    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (wr_ok && bank == BANK_CODE && idx == IDX_W'(k))
                code_q[k] <= wr_data;
        end
        always_ff @(posedge clk) begin
            if (wr_ok && bank == BANK_MASK && idx == IDX_W'(k))
                mask_q[k] <= wr_data;
        end
    end

    always_comb begin
        unique case (bank)
            BANK_CODE: rd_data = code_q[idx];
            BANK_MASK: rd_data = mask_q[idx];
            default:   rd_data = '0;
        endcase
    end

    // Locked writes must not disturb the filter.
    assert_lock_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && cfg_mode) |=> ($stable(code_q) && $stable(mask_q)));

endmodule

// File: rtl/idf_match.sv
module idf_match
    import idf_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0] id_b,
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0] code_b,
    input  logic [NUM_BYTES-1:0][BYTE_W-1:0] mask_b,
    output logic                             hit
);

    logic [NUM_BYTES-1:0] byte_hit;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_cmp
        assign byte_hit[k] = byte_match(id_b[k], code_b[k], mask_b[k]);
    end

    assign hit = &byte_hit;

    // An all-ones mask accepts anything.
    assert_all_dont_care_R2: assert property (@(posedge clk) disable iff (rst)
        (&mask_b) |-> hit);

    // An all-zero mask demands identity.
    assert_exact_only_R1: assert property (@(posedge clk) disable iff (rst)
        (mask_b == '0) |-> (hit == (id_b == code_b)));

endmodule

// File: rtl/idf_accept.sv
module idf_accept
    import idf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmp_res_t res,
    output logic     accept
);

    always_ff @(posedge clk) begin
        if (rst)
            accept <= 1'b0;
        else if (res.valid)
            accept <= res.hit;
    end

    assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (rst)
        !res.valid |=> $stable(accept));

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> !accept);

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
    import idf_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned ID_W   = NUM_BYTES * BYTE_W,
    localparam int unsigned ADDR_W = $clog2(NUM_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              id_valid,
    input  logic [ID_W-1:0]   id_bytes,
    output logic              accept
);

    logic [NUM_BYTES-1:0][BYTE_W-1:0] code_q;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] mask_q;
    logic [NUM_BYTES-1:0][BYTE_W-1:0] id_arr;
    logic                             hit;
    cmp_res_t                         res;

    assign id_arr = id_bytes;

    idf_regbank #(.NUM_BYTES(NUM_BYTES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .cfg_mode(cfg_mode),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .code_q  (code_q),
        .mask_q  (mask_q)
    );

    idf_match #(.NUM_BYTES(NUM_BYTES)) u_match (
        .clk   (clk),
        .rst   (rst),
        .id_b  (id_arr),
        .code_b(code_q),
        .mask_b(mask_q),
        .hit   (hit)
    );

    assign res.valid = id_valid;
    assign res.hit   = hit;

    idf_accept u_acc (
        .clk   (clk),
        .rst   (rst),
        .res   (res),
        .accept(accept)
    );

    // The verdict after a strobe is the comparator's result on the strobe edge.
    assert_verdict_follows_R3: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> (accept == $past(hit)));

endmodule

// File: tb/id_accept_filter_tb_top.sv
`timescale 1ns/1ps
module id_accept_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_mode;
    logic        reg_wr_en;
    logic [2:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        id_valid;
    logic [31:0] id_bytes;
    logic        accept;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;
    logic [31:0] sh_code, sh_mask;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    id_accept_filter dut_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .id_valid(id_valid), .id_bytes(id_bytes),
        .accept(accept)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    function automatic logic exp_accept(input logic [31:0] id, input logic [31:0] c, input logic [31:0] m);
        return ((id ^ c) & ~m) == 32'h0;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (cfg_mode) begin
            if (a[2]) sh_mask[8*a[1:0] +: 8] = d;
            else      sh_code[8*a[1:0] +: 8] = d;
        end
    endtask

    task automatic load_filter(input logic [31:0] c, input logic [31:0] m);
        logic keep = cfg_mode;
        cfg_mode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wreg(3'(k), c[8*k +: 8]);
            wreg(3'(4 + k), m[8*k +: 8]);
        end
        cfg_mode = keep;
    endtask

    task automatic readback_all(input string tag);
        for (int a = 0; a < 8; a++) begin
            logic [7:0] e = a[2] ? sh_mask[8*(a%4) +: 8] : sh_code[8*(a%4) +: 8];
            @(negedge clk);
            reg_addr = 3'(a);
            #1;
            check(reg_rdata === e, tag, 32'(reg_rdata), 32'(e));
        end
    endtask

    task automatic apply(input logic [31:0] id, input string tag);
        logic e = exp_accept(id, sh_code, sh_mask);
        @(negedge clk);
        id_bytes = id; id_valid = 1'b1;
        @(negedge clk);
        id_valid = 1'b0;
        check(accept === e, tag, 32'(accept), 32'(e));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; cfg_mode = 1'b1; reg_wr_en = 1'b0; reg_addr = '0;
        reg_wdata = '0; id_valid = 1'b0; id_bytes = '0;
        sh_code = '0; sh_mask = '0;
        repeat (3) @(negedge clk);
        check(accept === 1'b0, "R8 reset state", 32'(accept), 0);

        // R6: address map written during reset, read back.
        load_filter(32'h81_0F_3C_A5, 32'hFF_FF_FF_FF);
        readback_all("R6 map readback");
        @(negedge clk); rst = 1'b0;

        // R2: all-ones mask accepts anything.
        for (int i = 0; i < 64; i++) begin
            seed = next_rand(seed);
            apply(seed, "R2 all dont-care");
        end

        // R1/R3: exact match and every single-bit flip, mask 0.
        load_filter(32'h5A_C3_17_E8, 32'h0);
        apply(32'h5A_C3_17_E8, "R1 exact match");
        for (int b = 0; b < 32; b++)
            apply(32'h5A_C3_17_E8 ^ (32'h1 << b), "R1 single-bit flip rejected");

        // R2: the flipped bit alone made don't-care is forgiven.
        for (int b = 0; b < 32; b++) begin
            load_filter(32'h5A_C3_17_E8, 32'h1 << b);
            apply(32'h5A_C3_17_E8 ^ (32'h1 << b), "R2 masked flip accepted");
            apply(32'h5A_C3_17_E8 ^ (32'h1 << ((b + 1) % 32)), "R3 other bit still checked");
        end

        // Standard-format use: low three bits of mask byte 1 don't-care.
        load_filter(32'h00_00_A0_00, 32'h00_00_07_00);
        for (int v = 0; v < 8; v++)
            apply(32'h00_00_A0_00 | (32'(v) << 8), "R2 standard-id low bits ignored");
        apply(32'h00_00_A8_00, "R1 standard-id bit 3 checked");

        // R7: verdict held while no strobe.
        load_filter(32'hDEAD_BEEF, 32'h0);
        apply(32'hDEAD_BEEF, "R7 setup accept");
        @(negedge clk); id_bytes = 32'h0;
        repeat (3) @(negedge clk);
        check(accept === 1'b1, "R7 held without strobe", 32'(accept), 1);
        apply(32'h0, "R7 next strobe updates");
        @(negedge clk); id_bytes = 32'hDEAD_BEEF;
        repeat (2) @(negedge clk);
        check(accept === 1'b0, "R7 reject held", 32'(accept), 0);

        // R4: locked writes dropped; R6 readback in locked mode.
        cfg_mode = 1'b0;
        for (int a = 0; a < 8; a++) wreg(3'(a), 8'h3C ^ 8'(a));
        readback_all("R4 locked write ignored");
        apply(32'hDEAD_BEEF, "R4 filter unchanged after locked writes");

        // R5: reset leaves filter bytes intact.
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(accept === 1'b0, "R8 reset clears verdict", 32'(accept), 0);
        rst = 1'b0;
        readback_all("R5 contents persist through reset");
        apply(32'hDEAD_BEEF, "R5 filter works after reset");

        // R3: random codes, masks and near-matching identifiers.
        for (int i = 0; i < 300; i++) begin
            logic [31:0] c, m, d;
            seed = next_rand(seed); c = seed;
            seed = next_rand(seed); m = seed & next_rand(seed ^ 32'h9E37_79B9);
            seed = next_rand(seed); d = seed & next_rand(seed) & next_rand(seed ^ 32'h55);
            load_filter(c, m);
            apply(c ^ d, "R3 random masked compare");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule